// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This unit gathers the interrupt conditions of a two-channel serial controller into one status vector. It qualifies that vector with a host-writable mask and drives a single active-low request line. Because the line is open drain, the unit does not drive a level. It outputs a pull-low enable, and an external pull-up supplies the inactive level.

Each channel owns a group of four adjacent status bits: transmitter ready, receiver ready (or FIFO full), break change, and one auxiliary event. The auxiliary slot of channel 0 carries the counter-ready event. The auxiliary slot of channel 1 carries the input-port change event. The ready bits follow their level conditions. The other bits hold until a particular bus side effect removes them:

- a transmit holding register write,
- a receive holding register read,
- a reset-break-change command,
- a stop-counter command,
- a change-register read.

The host decodes these and presents them as single-cycle strobes.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is low, the status vector, the mask and the pull-low enable are all zero.
- R2: Channel c occupies status bits 4c..4c+3 in this order: +0 transmitter ready, +1 receiver ready/FIFO full, +2 break change, +3 auxiliary event (channel 0: counter ready; channel 1: input-port change). With two channels, bit 3 is the counter bit and bit 7 is the input-change bit.
- R3: On each clock, the transmitter-ready bit takes the channel's transmitter-ready level. It takes 0 instead in a cycle where that channel's transmit-holding write strobe is high.
- R4: On each clock, the receiver-ready bit takes the channel's receiver-ready level. It takes 0 instead in a cycle where that channel's receive-holding read strobe is high.
- R5: A break-change event pulse sets the channel's break bit. The bit stays set until a reset-break-change command strobe for that channel clears it. If the event and the clear come in the same cycle, the bit is set.
- R6: A counter-ready event sets bit 3. It stays set until a stop-counter strobe, and an event in the same cycle as the strobe wins.
- R7: An input-port change event sets bit 7. It stays set until a change-register read strobe, and an event in the same cycle as the strobe wins.
- R8: A mask write loads all mask bits from the write data. Without a write, the mask holds its value.
- R9: The pull-low enable is 1 exactly when status AND mask is non-zero. It changes on the same clock edge as the status or mask change that causes it.
- R10: The mask has no effect on the status bits. A status bit whose mask bit is cleared stays visible but does not contribute to the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_rdy_i | input | N_CH | Transmitter-ready level per channel |
| rx_rdy_i | input | N_CH | Receiver-ready / FIFO-full level per channel |
| thr_wr_i | input | N_CH | Transmit holding register write strobe per channel |
| rhr_rd_i | input | N_CH | Receive holding register read strobe per channel |
| brk_evt_i | input | N_CH | Break-change event pulse per channel |
| brk_clr_i | input | N_CH | Reset-break-change command strobe per channel |
| aux_evt_i | input | N_CH | Auxiliary event pulse (slot 0 counter ready, slot 1 input change) |
| aux_clr_i | input | N_CH | Auxiliary clear strobe (slot 0 stop counter, slot 1 change-register read) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 4*N_CH | Mask write data |
| stat_o | output | 4*N_CH | Status register |
| mask_o | output | 4*N_CH | Mask register |
| irq_pull_en_o | output | 1 | Pull-low enable for the open-drain request line |

## Verification
The bench uses the default of two channels. This gives an 8-bit status and mask, so every one of the 256 mask values can be swept. Each mask value is paired with an arithmetically derived mix of levels, events and clear strobes. The expected status, mask and request are recomputed in the bench every cycle. Directed sequences then cover the same-cycle set/clear race, the one-cycle suppression caused by holding-register strobes, masking of a pending bit, and a reset in the middle of a run.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int SLOTS_PER_CH = 4;

  typedef enum logic [1:0] {
    SLOT_TX  = 2'd0,
    SLOT_RX  = 2'd1,
    SLOT_BRK = 2'd2,
    SLOT_AUX = 2'd3
  } slot_e;
endpackage

// File: rtl/irq_src_bit.sv
// One status bit. STICKY=0: follows a level, forced low by a kill strobe.
// STICKY=1: set by a pulse, held until a clear strobe; set wins.
module irq_src_bit #(
  parameter bit STICKY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  logic bit_q;
  logic bit_d;
  logic bit_en;

  generate
    if (STICKY) begin : g_sticky
      always_comb begin
        bit_en = cond_i | clr_i;
        bit_d  = cond_i;
      end
    end else begin : g_level
      always_comb begin
        bit_en = 1'b1;
        bit_d  = cond_i & ~clr_i;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (bit_en) begin
      bit_q <= bit_d;
    end
  end

  assign nxt_o = bit_en ? bit_d : bit_q;
  assign q_o   = bit_q;
endmodule

// File: rtl/irq_chan_slice.sv
module irq_chan_slice
  import irq_stat_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_rdy_i,
  input  logic                    rx_rdy_i,
  input  logic                    thr_wr_i,
  input  logic                    rhr_rd_i,
  input  logic                    brk_evt_i,
  input  logic                    brk_clr_i,
  input  logic                    aux_evt_i,
  input  logic                    aux_clr_i,
  output logic [SLOTS_PER_CH-1:0] nxt_o,
  output logic [SLOTS_PER_CH-1:0] q_o
);
  logic [SLOTS_PER_CH-1:0] src_cond;
  logic [SLOTS_PER_CH-1:0] src_clr;

  always_comb begin
    src_cond[int'(SLOT_TX)]  = tx_rdy_i;
    src_clr [int'(SLOT_TX)]  = thr_wr_i;
    src_cond[int'(SLOT_RX)]  = rx_rdy_i;
    src_clr [int'(SLOT_RX)]  = rhr_rd_i;
    src_cond[int'(SLOT_BRK)] = brk_evt_i;
    src_clr [int'(SLOT_BRK)] = brk_clr_i;
    src_cond[int'(SLOT_AUX)] = aux_evt_i;
    src_clr [int'(SLOT_AUX)] = aux_clr_i;
  end

  for (genvar s = 0; s < SLOTS_PER_CH; s++) begin : g_slot
    localparam bit IS_STICKY = (s >= int'(SLOT_BRK));
    irq_src_bit #(.STICKY(IS_STICKY)) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (src_cond[s]),
      .clr_i  (src_clr[s]),
      .nxt_o  (nxt_o[s]),
      .q_o    (q_o[s])
    );
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  input  logic [W-1:0] stat_nxt_i,
  output logic [W-1:0] mask_o,
  output logic         req_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         req_q;
  logic         req_d;

  always_comb begin
    mask_d = mask_we_i ? mask_wdata_i : mask_q;
    req_d  = |(stat_nxt_i & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign mask_o = mask_q;
  assign req_o  = req_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int N_CH = 2,
  localparam int STAT_W = SLOTS_PER_CH * N_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   tx_rdy_i,
  input  logic [N_CH-1:0]   rx_rdy_i,
  input  logic [N_CH-1:0]   thr_wr_i,
  input  logic [N_CH-1:0]   rhr_rd_i,
  input  logic [N_CH-1:0]   brk_evt_i,
  input  logic [N_CH-1:0]   brk_clr_i,
  input  logic [N_CH-1:0]   aux_evt_i,
  input  logic [N_CH-1:0]   aux_clr_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_pull_en_o
);
  logic [STAT_W-1:0] stat_nxt;
  logic [STAT_W-1:0] stat_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    irq_chan_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_rdy_i  (tx_rdy_i[c]),
      .rx_rdy_i  (rx_rdy_i[c]),
      .thr_wr_i  (thr_wr_i[c]),
      .rhr_rd_i  (rhr_rd_i[c]),
      .brk_evt_i (brk_evt_i[c]),
      .brk_clr_i (brk_clr_i[c]),
      .aux_evt_i (aux_evt_i[c]),
      .aux_clr_i (aux_clr_i[c]),
      .nxt_o     (stat_nxt[c*SLOTS_PER_CH +: SLOTS_PER_CH]),
      .q_o       (stat_q[c*SLOTS_PER_CH +: SLOTS_PER_CH])
    );
  end

  irq_req_gen #(.W(STAT_W)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .stat_nxt_i   (stat_nxt),
    .mask_o       (mask_o),
    .req_o        (irq_pull_en_o)
  );

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int N_CH = 2,
  localparam int STAT_W = 4 * N_CH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   tx_rdy_i,
  input logic [N_CH-1:0]   rx_rdy_i,
  input logic [N_CH-1:0]   thr_wr_i,
  input logic [N_CH-1:0]   rhr_rd_i,
  input logic [N_CH-1:0]   brk_evt_i,
  input logic [N_CH-1:0]   brk_clr_i,
  input logic [N_CH-1:0]   aux_evt_i,
  input logic [N_CH-1:0]   aux_clr_i,
  input logic              mask_we_i,
  input logic [STAT_W-1:0] mask_wdata_i,
  input logic [STAT_W-1:0] stat_o,
  input logic [STAT_W-1:0] mask_o,
  input logic              irq_pull_en_o
);
  assert_req_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_en_o == |(stat_o & mask_o));

  assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_wdata_i)));

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assert_tx_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_wr_i[c] |=> (stat_o[4*c] == $past(tx_rdy_i[c])));
    assert_tx_kill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr_i[c] |=> !stat_o[4*c]);
    assert_rx_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rhr_rd_i[c] |=> (stat_o[4*c+1] == $past(rx_rdy_i[c])));
    assert_rx_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rhr_rd_i[c] |=> !stat_o[4*c+1]);
    assert_brk_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt_i[c] |=> stat_o[4*c+2]);
    assert_brk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[4*c+2] && !brk_clr_i[c]) |=> stat_o[4*c+2]);
    assert_brk_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_clr_i[c] && !brk_evt_i[c]) |=> !stat_o[4*c+2]);
    // aux slot: counter ready (R6) on channel 0, input change (R7) on channel 1
    assert_aux_set_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
      aux_evt_i[c] |=> stat_o[4*c+3]);
    assert_aux_clr_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_clr_i[c] && !aux_evt_i[c]) |=> !stat_o[4*c+3]);
    assert_aux_hold_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[4*c+3] && !aux_clr_i[c]) |=> stat_o[4*c+3]);
  end
endmodule

bind irq_status_unit irq_status_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH = 2;
  localparam int W = 4 * N_CH;

  logic          clk;
  logic          rst_n;
  logic [N_CH-1:0] tx_rdy, rx_rdy, thr_wr, rhr_rd, brk_evt, brk_clr, aux_evt, aux_clr;
  logic          mask_we;
  logic [W-1:0]  mask_wdata;
  logic [W-1:0]  stat;
  logic [W-1:0]  mask;
  logic          irq_en;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] exp_stat;
  logic [W-1:0] exp_mask;
  logic         exp_irq;

  irq_status_unit #(.N_CH(N_CH)) i_irq_status_unit (
    .clk(clk), .rst_n(rst_n),
    .tx_rdy_i(tx_rdy), .rx_rdy_i(rx_rdy), .thr_wr_i(thr_wr), .rhr_rd_i(rhr_rd),
    .brk_evt_i(brk_evt), .brk_clr_i(brk_clr), .aux_evt_i(aux_evt), .aux_clr_i(aux_clr),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .stat_o(stat), .mask_o(mask), .irq_pull_en_o(irq_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_rdy = '0; rx_rdy = '0; thr_wr = '0; rhr_rd = '0;
    brk_evt = '0; brk_clr = '0; aux_evt = '0; aux_clr = '0;
    mask_we = 1'b0; mask_wdata = '0;
  endtask

  // expected next values from the requirements, then one clock, then compare
  task automatic step(input string stat_req);
    logic [W-1:0] ns;
    for (int c = 0; c < N_CH; c++) begin
      ns[4*c]   = tx_rdy[c] & ~thr_wr[c];
      ns[4*c+1] = rx_rdy[c] & ~rhr_rd[c];
      ns[4*c+2] = brk_evt[c] | (exp_stat[4*c+2] & ~brk_clr[c]);
      ns[4*c+3] = aux_evt[c] | (exp_stat[4*c+3] & ~aux_clr[c]);
    end
    exp_stat = ns;
    if (mask_we) exp_mask = mask_wdata;
    exp_irq = |(exp_stat & exp_mask);
    @(posedge clk);
    #1;
    chk(stat_req, stat, exp_stat);
    chk("R8", mask, exp_mask);
    chk("R9", {{(W-1){1'b0}}, irq_en}, {{(W-1){1'b0}}, exp_irq});
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    exp_stat = '0;
    exp_mask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", stat, '0);
    chk("R1", mask, '0);
    chk("R1", {{(W-1){1'b0}}, irq_en}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: transmitter level tracked, write strobe suppresses
    tx_rdy = 2'b01; step("R3");
    tx_rdy = 2'b01; thr_wr = 2'b01; step("R3");
    chk("R3", {7'd0, stat[0]}, 8'd0);
    tx_rdy = 2'b10; step("R3");
    chk("R2", stat, 8'h10);
    // R4: receiver level tracked, read strobe suppresses
    rx_rdy = 2'b11; step("R4");
    chk("R4", stat, 8'h22);
    rx_rdy = 2'b11; rhr_rd = 2'b10; step("R4");
    chk("R4", stat, 8'h02);
    // R5: break set, set wins over clear, clear alone
    brk_evt = 2'b10; brk_clr = 2'b10; step("R5");
    chk("R5", stat, 8'h40);
    step("R5");
    chk("R5", stat, 8'h40);
    brk_clr = 2'b10; step("R5");
    chk("R5", stat, 8'h00);
    // R6: counter bit 3
    aux_evt = 2'b01; step("R6");
    chk("R6", stat, 8'h08);
    aux_evt = 2'b01; aux_clr = 2'b01; step("R6");
    chk("R6", stat, 8'h08);
    aux_clr = 2'b01; step("R6");
    chk("R6", stat, 8'h00);
    // R7 and R10: input change bit 7, mask interplay
    mask_we = 1'b1; mask_wdata = 8'h80; aux_evt = 2'b10; step("R7");
    chk("R7", stat, 8'h80);
    chk("R10", {7'd0, irq_en}, 8'd1);
    mask_we = 1'b1; mask_wdata = 8'h7F; step("R10");
    chk("R10", stat, 8'h80);
    chk("R10", {7'd0, irq_en}, 8'd0);
    aux_clr = 2'b10; step("R7");
    chk("R7", stat, 8'h00);

    // R9 sweep over every mask value with mixed stimulus
    for (int m = 0; m < 256; m++) begin
      logic [7:0] p;
      logic [7:0] q;
      p = 8'((m * 29 + 7) & 255);
      q = 8'((m * 53 + 3) & 255);
      mask_we = 1'b1; mask_wdata = 8'(m);
      tx_rdy = p[1:0]; rx_rdy = p[3:2]; brk_evt = p[5:4]; aux_evt = p[7:6];
      thr_wr = q[1:0]; rhr_rd = q[3:2]; brk_clr = q[5:4]; aux_clr = q[7:6];
      step("R2");
      if (m % 3 == 0) step("R2");
    end

    // R1: reset mid-run
    mask_we = 1'b1; mask_wdata = 8'hFF; brk_evt = 2'b11; step("R5");
    rst_n = 1'b0;
    #2;
    chk("R1", stat, '0);
    chk("R1", mask, '0);
    chk("R1", {{(W-1){1'b0}}, irq_en}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_stat = '0;
    exp_mask = '0;
    step("R1");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule